// File: doc/BRIEF.md
# Four-Channel Register Bank with Group Writes

This block stores the control registers of a four-lane device. An 8-bit register address reaches it from a serial control target, for example an I2C target. The upper three address bits pick one of eight 32-byte windows, and the lower five bits pick an offset inside that window. Four windows give private access to the copy that each channel owns. Three windows are group windows: one write lands in several channel copies at once, and a read returns the copy of one fixed channel. The last window holds a single set of registers that all channels share.

The host side uses a plain strobe interface: a write strobe with address and data, a read strobe with address, and read data that is registered. The block also turns two strapped level codes into the 7-bit address that the serial target answers on. It flags the reserved level so that the target stays silent for it.

Top module: `chan_regbank`

## Requirements
- R1: After a synchronous reset every channel register and every shared register is 0x00, and `rdata` is 0x00.
- R2: Address bits [7:5] select the window and bits [4:0] select the offset. Windows 0, 1, 2 and 3 (bases 0x00, 0x20, 0x40, 0x60) read and write only the copy of channel 0, 1, 2 and 3.
- R3: A write in window 4 (base 0x80) stores the data at that offset in all four channels. A read there returns channel 0's copy.
- R4: A write in window 5 (base 0xA0) stores the data in channels 0 and 1 only. A read there returns channel 0's copy.
- R5: A write in window 6 (base 0xC0) stores the data in channels 2 and 3 only. A read there returns channel 2's copy.
- R6: Window 7 (base 0xE0) reaches one set of 32 registers shared by all channels. Writes there leave every channel copy unchanged, and channel writes leave it unchanged.
- R7: `rdata` updates on the clock edge that samples `rd_en` high. It holds its value in every cycle without a read.
- R8: A write is visible to a read strobed in the next cycle, in every window that reaches a copy it updated.
- R9: A read and a write in the same cycle to the same location return the old value. The new value is stored at the end of that cycle.
- R10: Strap codes 0..3 mean levels 0..3, and code 4 or above is reserved. With both codes valid, `tgt_addr_ok` is 1 and `tgt_addr` = 0x18 + 8*hi + 2*lo. With either code reserved, `tgt_addr_ok` is 0 and `tgt_addr` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_hi | input | 3 | Level code of the upper address strap |
| strap_lo | input | 3 | Level code of the lower address strap |
| tgt_addr | output | 7 | Serial target address decoded from the straps |
| tgt_addr_ok | output | 1 | High when both strap codes are usable |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address: window in [7:5], offset in [4:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The readback properties assume that the host holds the address across a write followed by a read strobe in the next cycle, and that the second cycle carries no write. The stimulus keeps to the one-strobe-per-cycle interface and drives inputs only on the falling edge. Random addresses are often confined to a few offsets, so that group writes, private writes and reads collide on the same location. The strap inputs are swept over all eight codes on each side, which includes every reserved combination.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int CR_NCH   = 4;
    localparam int CR_WIN_W = 3;
    localparam int CR_SEL_W = $clog2(CR_NCH);
    localparam int CR_LVL_W = 3;
    localparam int CR_TA_W  = 7;

    typedef enum logic [CR_WIN_W-1:0] {
        WIN_CH0    = 3'd0,
        WIN_CH1    = 3'd1,
        WIN_CH2    = 3'd2,
        WIN_CH3    = 3'd3,
        WIN_GRP_ALL = 3'd4,
        WIN_GRP_LO = 3'd5,
        WIN_GRP_HI = 3'd6,
        WIN_SHARED = 3'd7
    } win_e;

    typedef struct packed {
        logic [CR_NCH-1:0]   wmask;
        logic [CR_SEL_W-1:0] rsel;
        logic                shared;
    } route_t;

    typedef struct packed {
        logic               ok;
        logic [CR_TA_W-1:0] addr;
    } strap_t;

    function automatic route_t route_of(win_e w);
        route_t r;
        r = '{wmask: '0, rsel: '0, shared: 1'b0};
        unique case (w)
            WIN_CH0:     begin r.wmask = 4'b0001; r.rsel = 2'd0; end
            WIN_CH1:     begin r.wmask = 4'b0010; r.rsel = 2'd1; end
            WIN_CH2:     begin r.wmask = 4'b0100; r.rsel = 2'd2; end
            WIN_CH3:     begin r.wmask = 4'b1000; r.rsel = 2'd3; end
            WIN_GRP_ALL: begin r.wmask = 4'b1111; r.rsel = 2'd0; end
            WIN_GRP_LO:  begin r.wmask = 4'b0011; r.rsel = 2'd0; end
            WIN_GRP_HI:  begin r.wmask = 4'b1100; r.rsel = 2'd2; end
            WIN_SHARED:  begin r.shared = 1'b1; end
            default:     r.shared = 1'b0;
        endcase
        return r;
    endfunction

    function automatic strap_t strap_map(logic [CR_LVL_W-1:0] hi, logic [CR_LVL_W-1:0] lo);
        strap_t s;
        s.ok = (hi < 3'd4) && (lo < 3'd4);
        if (s.ok)
            s.addr = 7'h18 + {2'b00, hi[1:0], 3'b000} + {4'b0000, lo[1:0], 1'b0};
        else
            s.addr = '0;
        return s;
    endfunction

endpackage

// File: rtl/cr_strap_decode.sv
module cr_strap_decode
    import cr_pkg::*;
(
    input  logic [CR_LVL_W-1:0] lvl_hi,
    input  logic [CR_LVL_W-1:0] lvl_lo,
    output strap_t              strap
);
    always_comb strap = strap_map(lvl_hi, lvl_lo);
endmodule

// File: rtl/cr_win_decode.sv
module cr_win_decode
    import cr_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int OFF_W = ADDR_W - CR_WIN_W
) (
    input  logic [ADDR_W-1:0] addr,
    output route_t            route,
    output logic [OFF_W-1:0]  offset
);
    win_e win;
    always_comb begin
        win    = win_e'(addr[ADDR_W-1 -: CR_WIN_W]);
        route  = route_of(win);
        offset = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/cr_reg_array.sv
module cr_reg_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] rval
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[idx] <= wval;
        end
    end

    assign rval = cell_q[idx];
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
    import cr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int OFF_W = ADDR_W - CR_WIN_W,
    localparam int DEPTH = 2 ** OFF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CR_LVL_W-1:0] strap_hi,
    input  logic [CR_LVL_W-1:0] strap_lo,
    output logic [CR_TA_W-1:0]  tgt_addr,
    output logic                tgt_addr_ok,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    strap_t            strap;
    route_t            route;
    logic [OFF_W-1:0]  offset;
    logic [DATA_W-1:0] ch_rd [CR_NCH];
    logic [DATA_W-1:0] sh_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    cr_strap_decode u_strap (
        .lvl_hi (strap_hi),
        .lvl_lo (strap_lo),
        .strap  (strap)
    );

    assign tgt_addr    = strap.addr;
    assign tgt_addr_ok = strap.ok;

    cr_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .route  (route),
        .offset (offset)
    );

    for (genvar c = 0; c < CR_NCH; c++) begin : g_ch
        cr_reg_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_arr (
            .clk  (clk),
            .rst  (rst),
            .we   (wr_en & route.wmask[c]),
            .idx  (offset),
            .wval (wdata),
            .rval (ch_rd[c])
        );
    end

    cr_reg_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_shared (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en & route.shared),
        .idx  (offset),
        .wval (wdata),
        .rval (sh_rd)
    );

    always_comb rd_mux = route.shared ? sh_rd : ch_rd[route.rsel];

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/chan_regbank_chk.sv
module chan_regbank_chk
    import cr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [CR_LVL_W-1:0] strap_hi,
    input logic [CR_LVL_W-1:0] strap_lo,
    input logic [CR_TA_W-1:0]  tgt_addr,
    input logic                tgt_addr_ok,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata
);
    localparam int OFF_W = ADDR_W - CR_WIN_W;
    logic [CR_WIN_W-1:0] win;
    logic [OFF_W-1:0]    off;
    assign win = addr[ADDR_W-1 -: CR_WIN_W];
    assign off = addr[OFF_W-1:0];

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> rdata == '0); // R1

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R7

    AST_SAME_ADDR_READBACK: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) ##1 (rd_en && !wr_en && addr == $past(addr))
        |=> rdata == $past(wdata, 2)); // R8

    AST_GRP_ALL_REACH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && win == 3'd4) ##1
        (rd_en && !wr_en && win[2] == 1'b0 && off == $past(off))
        |=> rdata == $past(wdata, 2)); // R3

    AST_GRP_LO_REACH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && win == 3'd5) ##1
        (rd_en && !wr_en && win[2:1] == 2'b00 && off == $past(off))
        |=> rdata == $past(wdata, 2)); // R4

    AST_GRP_HI_REACH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en && win == 3'd6) ##1
        (rd_en && !wr_en && win[2:1] == 2'b01 && off == $past(off))
        |=> rdata == $past(wdata, 2)); // R5

    always_comb begin
        if (!rst) begin
            AST_STRAP_RESERVED: assert ((strap_hi < 3'd4 && strap_lo < 3'd4) == tgt_addr_ok); // R10
            AST_STRAP_RANGE: assert (!tgt_addr_ok ||
                (tgt_addr >= 7'h18 && tgt_addr <= 7'h36 && !tgt_addr[0])); // R10
        end
    end
endmodule

bind chan_regbank chan_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strap_hi    (strap_hi),
    .strap_lo    (strap_lo),
    .tgt_addr    (tgt_addr),
    .tgt_addr_ok (tgt_addr_ok),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata)
);

// File: tb/sim_chan_regbank.sv
`timescale 1ns/1ps
module sim_chan_regbank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] strap_hi = '0;
    logic [2:0] strap_lo = '0;
    logic [6:0] tgt_addr;
    logic       tgt_addr_ok;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr  = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] ch_m [4][32];
    logic [7:0] sh_m [32];
    logic [7:0] last_rd;

    always #4 clk = ~clk;

    chan_regbank u0 (
        .clk(clk), .rst(rst), .strap_hi(strap_hi), .strap_lo(strap_lo),
        .tgt_addr(tgt_addr), .tgt_addr_ok(tgt_addr_ok),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(logic [7:0] a);
        int w = int'(a[7:5]);
        int o = int'(a[4:0]);
        case (w)
            0, 1, 2, 3: return ch_m[w][o];
            4, 5:       return ch_m[0][o];
            6:          return ch_m[2][o];
            default:    return sh_m[o];
        endcase
    endfunction

    function automatic logic [3:0] model_mask(logic [7:0] a);
        case (a[7:5])
            3'd0: return 4'b0001;
            3'd1: return 4'b0010;
            3'd2: return 4'b0100;
            3'd3: return 4'b1000;
            3'd4: return 4'b1111;
            3'd5: return 4'b0011;
            3'd6: return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        case (a[7:5])
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            3'd7: return "R6";
            default: return "R2";
        endcase
    endfunction

    // called on a falling edge; returns on the next falling edge
    task automatic op(bit w, bit r, logic [7:0] a, logic [7:0] d, string req);
        logic [7:0] exp;
        logic [3:0] m;
        exp = r ? model_rd(a) : last_rd;
        if (w) begin
            m = model_mask(a);
            for (int c = 0; c < 4; c++) if (m[c]) ch_m[c][a[4:0]] = d;
            if (a[7:5] == 3'd7) sh_m[a[4:0]] = d;
        end
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (r) check(rdata == exp, req, rdata, exp);
        else   check(rdata == exp, "R7", rdata, exp);
        last_rd = exp;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int c = 0; c < 4; c++) for (int o = 0; o < 32; o++) ch_m[c][o] = '0;
        for (int o = 0; o < 32; o++) sh_m[o] = '0;
        last_rd = '0;

        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check(rdata == 8'h00, "R1", rdata, 0);

        // R1: every location reads zero after reset
        for (int a = 0; a < 256; a++) op(0, 1, 8'(a), 8'h00, "R1");

        // R2: private windows are independent
        op(1, 0, 8'h05, 8'hA1, "R2");
        op(1, 0, 8'h25, 8'hB2, "R2");
        op(1, 0, 8'h45, 8'hC3, "R2");
        op(1, 0, 8'h65, 8'hD4, "R2");
        op(0, 1, 8'h05, 8'h00, "R2");
        op(0, 1, 8'h25, 8'h00, "R2");
        op(0, 1, 8'h45, 8'h00, "R2");
        op(0, 1, 8'h65, 8'h00, "R2");

        // R3: group write to all four channels
        op(1, 0, 8'h83, 8'h5A, "R3");
        op(0, 1, 8'h03, 8'h00, "R3");
        op(0, 1, 8'h23, 8'h00, "R3");
        op(0, 1, 8'h43, 8'h00, "R3");
        op(0, 1, 8'h63, 8'h00, "R3");
        op(1, 0, 8'h23, 8'h99, "R3");
        op(0, 1, 8'h83, 8'h00, "R3");

        // R4: group write to channels 0 and 1, read from channel 0
        op(1, 0, 8'h47, 8'h77, "R4");
        op(1, 0, 8'h67, 8'h88, "R4");
        op(1, 0, 8'hA7, 8'h11, "R4");
        op(0, 1, 8'h07, 8'h00, "R4");
        op(0, 1, 8'h27, 8'h00, "R4");
        op(0, 1, 8'h47, 8'h00, "R4");
        op(0, 1, 8'h67, 8'h00, "R4");
        op(1, 0, 8'h08, 8'h01, "R4");
        op(1, 0, 8'h28, 8'h02, "R4");
        op(0, 1, 8'hA8, 8'h00, "R4");

        // R5: group write to channels 2 and 3, read from channel 2
        op(1, 0, 8'h0B, 8'h33, "R5");
        op(1, 0, 8'h2B, 8'h44, "R5");
        op(1, 0, 8'hCB, 8'hE5, "R5");
        op(0, 1, 8'h0B, 8'h00, "R5");
        op(0, 1, 8'h2B, 8'h00, "R5");
        op(0, 1, 8'h4B, 8'h00, "R5");
        op(0, 1, 8'h6B, 8'h00, "R5");
        op(1, 0, 8'h4C, 8'h0C, "R5");
        op(1, 0, 8'h6C, 8'h0D, "R5");
        op(0, 1, 8'hCC, 8'h00, "R5");

        // R6: shared window is a separate set
        op(1, 0, 8'hE4, 8'h3C, "R6");
        op(0, 1, 8'h04, 8'h00, "R6");
        op(0, 1, 8'h84, 8'h00, "R6");
        op(1, 0, 8'h84, 8'hC6, "R6");
        op(0, 1, 8'hE4, 8'h00, "R6");

        // R7: idle cycles hold the last read value
        op(0, 1, 8'h05, 8'h00, "R7");
        op(0, 0, 8'h00, 8'h00, "R7");
        op(1, 0, 8'h05, 8'hFF, "R7");
        op(0, 0, 8'h00, 8'h00, "R7");

        // R8: write then read on the next cycle
        op(1, 0, 8'h3F, 8'h6E, "R8");
        op(0, 1, 8'h3F, 8'h00, "R8");
        op(1, 0, 8'hDF, 8'h71, "R8");
        op(0, 1, 8'h7F, 8'h00, "R8");

        // R9: same-cycle read and write return the old value
        op(1, 1, 8'h3F, 8'h12, "R9");
        op(0, 1, 8'h3F, 8'h00, "R9");
        op(1, 1, 8'h9E, 8'h34, "R9");
        op(0, 1, 8'h7E, 8'h00, "R9");
        op(1, 1, 8'hFE, 8'h56, "R9");
        op(0, 1, 8'hFE, 8'h00, "R9");

        // random mix on a narrow set of offsets
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            bit w, r;
            a[7:5] = 3'($urandom_range(0, 7));
            a[4:0] = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(0, 3));
            w = ($urandom_range(0, 1) == 1);
            r = ($urandom_range(0, 1) == 1);
            op(w, r, a, 8'($urandom), (w && r) ? "R9" : req_of(a));
        end

        // R10: strap sweep over all codes
        for (int h = 0; h < 8; h++) begin
            for (int l = 0; l < 8; l++) begin
                bit ok_e;
                int ta_e;
                strap_hi = 3'(h); strap_lo = 3'(l);
                #1;
                ok_e = (h < 4) && (l < 4);
                ta_e = ok_e ? (8'h18 + 8 * h + 2 * l) : 0;
                check(tgt_addr_ok == ok_e, "R10", int'(tgt_addr_ok), int'(ok_e));
                check(int'(tgt_addr) == ta_e, "R10", int'(tgt_addr), ta_e);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule